// File: doc/BRIEF.md
# Two-Level Page Translator with Translation Cache

This block maps 32-bit linear addresses to physical addresses. Memory is split into 4K-byte pages. The linear page number is looked up first in a 32-entry translation cache. On a hit, the physical address is produced one cycle after the request is accepted, and memory is not read. On a miss, the block walks two tables that live in memory. It reads one word from the page directory, whose frame is given by the `dirBase` input. That word names a page table, and the block then reads one word from that table. The cache is filled, and the block answers.

Each table word carries a 20-bit physical frame number in bits 31:12 and a present flag in bit 0. A clear present flag at either level ends the walk with a fault response, and nothing is cached. When the `pagingEn` input is low, the physical address is the linear address. A one-cycle `flushTlb` strobe empties the cache. Table reads use a request/response pair: the address is held until the word comes back.

Top module: `page_walk_xlate`

## Requirements
- R1: While reset is held, `reqReady` is 1, and `respValid` and `memReqValid` are 0.
- R2: A request accepted while `pagingEn` is 0 is answered on the next cycle with `respPhysAddr` equal to the linear address and `respFault` 0. No memory read is made, and the translation cache is left unchanged.
- R3: A paged request whose linear page is held in the cache is answered on the next cycle with `{cached frame, offset}` and no memory read.
- R4: On a miss, the block makes two reads in order. The first is at `{dirBase, lin[31:22], 2'b00}`. The second is at `{dirWord[31:12], lin[21:12], 2'b00}`. The response `{tableWord[31:12], lin[11:0]}` appears on the cycle after the second word is accepted.
- R5: A table word with bit 0 clear ends the walk with `respFault` 1 and `respPhysAddr` equal to the linear address. A clear directory word means no table read is made. A faulting page is not cached, so it walks again on the next request.
- R6: The cache fills empty entries first. Once all 32 entries are in use, a fill replaces the least recently used translation. Both hits and fills count as uses.
- R7: `flushTlb` empties the cache. A request accepted in the same cycle as the flush is treated as a miss.
- R8: During a walk, `reqReady` is 0. `memReqValid` and `memReqAddr` stay stable until `memRespValid` is seen.
- R9: Every `respValid` cycle follows either an accepted request or an accepted memory word on the previous cycle. Exactly one response is given per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pagingEn | input | 1 | 1 = translate, 0 = pass the address through |
| dirBase | input | 20 | Physical frame of the page directory |
| flushTlb | input | 1 | One-cycle strobe that empties the cache |
| reqValid | input | 1 | Translation request |
| reqReady | output | 1 | Block is idle and accepts a request |
| reqLinAddr | input | 32 | Linear address to translate |
| respValid | output | 1 | Response strobe, one cycle |
| respPhysAddr | output | 32 | Physical address, or the linear address on a fault |
| respFault | output | 1 | Page fault (entry not present) |
| memReqValid | output | 1 | Table read request, held until answered |
| memReqAddr | output | 32 | Byte address of the table word |
| memRespValid | input | 1 | Table word is valid this cycle |
| memRespData | input | 32 | Table word: frame in 31:12, present in bit 0 |

## Verification
The bench builds the block with its default parameters. With 32 cache entries, the bench can fill every entry, force evictions and track the exact recency order in a reference list.

The bench uses an arithmetic memory model in which every fourth directory slot out of seven is absent, and table slots 4, 9, 14 and so on are absent. A 64-page address pool is larger than the cache, so a long pseudo-random sweep exercises hits, both fault levels, thrashing and same-cycle flushes against the reference list.

// File: rtl/pwx_pkg.sv
package pwx_pkg;
  localparam int ADDR_W = 32;
  localparam int OFF_W = 12;
  localparam int DIR_W = 10;
  localparam int TBL_W = 10;
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int PRESENT_BIT = 0;

  typedef struct packed {
    logic capture;     // latch linear address, start a walk
    logic respDirect;  // answer with the untranslated address
    logic respHit;     // answer from the cache, refresh recency
    logic takeDir;     // latch page-table frame from directory word
    logic respWalk;    // answer from table word and fill the cache
    logic respFault;   // answer with a fault
    logic selTable;    // second-level read address
  } strobe_t;
endpackage

// File: rtl/pwx_tlb.sv
module pwx_tlb
  import pwx_pkg::*;
#(
  parameter int ENTRIES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PAGE_W-1:0] lookupPage,
  output logic              hit,
  output logic [PAGE_W-1:0] hitFrame,
  input  logic              touchHit,
  input  logic              fillEn,
  input  logic [PAGE_W-1:0] fillPage,
  input  logic [PAGE_W-1:0] fillFrame,
  input  logic              flush
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] valid;
  logic [PAGE_W-1:0]  tag   [ENTRIES];
  logic [PAGE_W-1:0]  frame [ENTRIES];
  logic [IW-1:0]      age   [ENTRIES];   // 0 = most recent, ENTRIES-1 = oldest

  logic [IW-1:0] hitIdx, freeIdx, lruIdx, victim, useIdx;
  logic          anyFree, doFill, useEn;

  always_comb begin
    hit = 1'b0;
    hitIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (valid[i] && tag[i] == lookupPage) begin
        hit = 1'b1;
        hitIdx = IW'(i);
      end
    end
  end

  assign hitFrame = frame[hitIdx];

  always_comb begin
    anyFree = 1'b0;
    freeIdx = '0;
    lruIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        anyFree = 1'b1;
        freeIdx = IW'(i);
      end
      if (age[i] == IW'(ENTRIES - 1)) lruIdx = IW'(i);
    end
  end

  assign victim = anyFree ? freeIdx : lruIdx;
  assign doFill = fillEn && !flush;
  assign useEn  = touchHit || doFill;
  assign useIdx = touchHit ? hitIdx : victim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= '0;
      for (int i = 0; i < ENTRIES; i++) age[i] <= IW'(i);
    end else begin
      if (flush) valid <= '0;
      else if (doFill) valid[victim] <= 1'b1;
      if (useEn) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (IW'(i) == useIdx) age[i] <= '0;
          else if (age[i] < age[useIdx]) age[i] <= age[i] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (doFill) begin
      tag[victim]   <= fillPage;
      frame[victim] <= fillFrame;
    end
  end
endmodule

// File: rtl/pwx_ctrl.sv
module pwx_ctrl
  import pwx_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    reqValid,
  input  logic    pagingEn,
  input  logic    flushTlb,
  input  logic    tlbHit,
  input  logic    memRespValid,
  input  logic    memPresent,
  output logic    reqReady,
  output logic    memReqValid,
  output strobe_t strb
);
  typedef enum logic [1:0] {S_IDLE, S_DIR, S_TBL} state_t;
  state_t state, nextState;

  always_comb begin
    strb = '0;
    nextState = state;
    unique case (state)
      S_IDLE: begin
        if (reqValid) begin
          if (!pagingEn) strb.respDirect = 1'b1;
          else if (tlbHit && !flushTlb) strb.respHit = 1'b1;
          else begin
            strb.capture = 1'b1;
            nextState = S_DIR;
          end
        end
      end
      S_DIR: begin
        if (memRespValid) begin
          if (memPresent) begin
            strb.takeDir = 1'b1;
            nextState = S_TBL;
          end else begin
            strb.respFault = 1'b1;
            nextState = S_IDLE;
          end
        end
      end
      S_TBL: begin
        strb.selTable = 1'b1;
        if (memRespValid) begin
          if (memPresent) strb.respWalk = 1'b1;
          else strb.respFault = 1'b1;
          nextState = S_IDLE;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else state <= nextState;
  end

  assign reqReady = (state == S_IDLE);
  assign memReqValid = (state != S_IDLE);
endmodule

// File: rtl/pwx_datapath.sv
module pwx_datapath
  import pwx_pkg::*;
#(
  parameter int TLB_ENTRIES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reqLinAddr,
  input  logic [PAGE_W-1:0] dirBase,
  input  logic              flushTlb,
  input  strobe_t           strb,
  input  logic [PAGE_W-1:0] memFrame,
  output logic              tlbHit,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic              respValid,
  output logic [ADDR_W-1:0] respPhysAddr,
  output logic              respFault
);
  localparam int ENT_SH = OFF_W - TBL_W;

  logic [ADDR_W-1:0] linReg;
  logic [PAGE_W-1:0] tblFrame, hitFrame;
  logic [DIR_W-1:0]  dirIdx;
  logic [TBL_W-1:0]  tblIdx;

  assign dirIdx = linReg[ADDR_W-1 -: DIR_W];
  assign tblIdx = linReg[OFF_W +: TBL_W];
  assign memReqAddr = strb.selTable ? {tblFrame, tblIdx, {ENT_SH{1'b0}}}
                                    : {dirBase, dirIdx, {ENT_SH{1'b0}}};

  pwx_tlb #(.ENTRIES(TLB_ENTRIES)) u_tlb (
    .clk       (clk),
    .rst_n     (rst_n),
    .lookupPage(reqLinAddr[ADDR_W-1:OFF_W]),
    .hit       (tlbHit),
    .hitFrame  (hitFrame),
    .touchHit  (strb.respHit),
    .fillEn    (strb.respWalk),
    .fillPage  (linReg[ADDR_W-1:OFF_W]),
    .fillFrame (memFrame),
    .flush     (flushTlb)
  );

  always_ff @(posedge clk) begin
    if (strb.capture) linReg <= reqLinAddr;
    if (strb.takeDir) tblFrame <= memFrame;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      respValid    <= 1'b0;
      respFault    <= 1'b0;
      respPhysAddr <= '0;
    end else begin
      respValid <= strb.respDirect | strb.respHit | strb.respWalk | strb.respFault;
      respFault <= strb.respFault;
      if (strb.respDirect) respPhysAddr <= reqLinAddr;
      else if (strb.respHit) respPhysAddr <= {hitFrame, reqLinAddr[OFF_W-1:0]};
      else if (strb.respWalk) respPhysAddr <= {memFrame, linReg[OFF_W-1:0]};
      else if (strb.respFault) respPhysAddr <= linReg;
    end
  end
endmodule

// File: rtl/page_walk_xlate.sv
module page_walk_xlate
  import pwx_pkg::*;
#(
  parameter int TLB_ENTRIES = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pagingEn,
  input  logic [19:0] dirBase,
  input  logic        flushTlb,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [31:0] reqLinAddr,
  output logic        respValid,
  output logic [31:0] respPhysAddr,
  output logic        respFault,
  output logic        memReqValid,
  output logic [31:0] memReqAddr,
  input  logic        memRespValid,
  input  logic [31:0] memRespData
);
  strobe_t           strb;
  logic              tlbHit;
  logic [PAGE_W-1:0] memFrame;
  logic              memPresent;
  logic              unusedPteBits;

  assign memFrame = memRespData[ADDR_W-1:OFF_W];
  assign memPresent = memRespData[PRESENT_BIT];
  assign unusedPteBits = ^memRespData[OFF_W-1:PRESENT_BIT+1];

  pwx_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .reqValid    (reqValid),
    .pagingEn    (pagingEn),
    .flushTlb    (flushTlb),
    .tlbHit      (tlbHit),
    .memRespValid(memRespValid),
    .memPresent  (memPresent),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .strb        (strb)
  );

  pwx_datapath #(.TLB_ENTRIES(TLB_ENTRIES)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .reqLinAddr  (reqLinAddr),
    .dirBase     (dirBase),
    .flushTlb    (flushTlb),
    .strb        (strb),
    .memFrame    (memFrame),
    .tlbHit      (tlbHit),
    .memReqAddr  (memReqAddr),
    .respValid   (respValid),
    .respPhysAddr(respPhysAddr),
    .respFault   (respFault)
  );
endmodule

// File: rtl/pwx_checker.sv
module pwx_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        pagingEn,
  input logic        reqValid,
  input logic        reqReady,
  input logic [31:0] reqLinAddr,
  input logic        respValid,
  input logic [31:0] respPhysAddr,
  input logic        respFault,
  input logic        memReqValid,
  input logic [31:0] memReqAddr,
  input logic        memRespValid,
  input logic [31:0] memRespData
);
  AST_BYPASS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && reqReady && !pagingEn |=> respValid && !respFault && respPhysAddr == $past(reqLinAddr)); // R2

  AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    memReqValid && !memRespValid |=> memReqValid && $stable(memReqAddr)); // R8

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    memReqValid |-> !reqReady); // R8

  AST_ABSENT_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    memReqValid && memRespValid && !memRespData[0] |=> respValid && respFault && !memReqValid); // R5

  AST_RESP_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    respValid |-> $past(reqValid && reqReady) || $past(memReqValid && memRespValid)); // R9
endmodule

bind page_walk_xlate pwx_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pagingEn    (pagingEn),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .reqLinAddr  (reqLinAddr),
  .respValid   (respValid),
  .respPhysAddr(respPhysAddr),
  .respFault   (respFault),
  .memReqValid (memReqValid),
  .memReqAddr  (memReqAddr),
  .memRespValid(memRespValid),
  .memRespData (memRespData)
);

// File: tb/test_page_walk_xlate.sv
module test_page_walk_xlate;
  localparam int ENTRIES = 32;
  localparam logic [19:0] DIRB = 20'h00400;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, pagingEn, flushTlb, reqValid, reqReady;
  logic [19:0] dirBase;
  logic [31:0] reqLinAddr, respPhysAddr, memReqAddr, memRespData;
  logic        respValid, respFault, memReqValid, memRespValid;

  page_walk_xlate #(.TLB_ENTRIES(ENTRIES)) i_page_walk_xlate (
    .clk(clk), .rst_n(rst_n), .pagingEn(pagingEn), .dirBase(dirBase),
    .flushTlb(flushTlb), .reqValid(reqValid), .reqReady(reqReady),
    .reqLinAddr(reqLinAddr), .respValid(respValid), .respPhysAddr(respPhysAddr),
    .respFault(respFault), .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRespValid(memRespValid), .memRespData(memRespData)
  );

  int checks = 0;
  int fails = 0;
  int lruQ[$];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] memModel(input logic [31:0] a);
    logic [9:0] d, t;
    logic [19:0] tf;
    if (a[31:12] == DIRB) begin
      d = a[11:2];
      if (d % 7 == 3) return 32'h0;
      return {20'h10000 + {10'h0, d}, 12'h001};
    end
    tf = a[31:12] - 20'h10000;
    d = tf[9:0];
    t = a[11:2];
    return {({d, t} ^ 20'h00100), 11'h0, (t % 5 != 4)};
  endfunction

  task automatic refAccess(input int pg, input bit cacheable, output bit wasHit);
    int pos = -1;
    for (int i = 0; i < lruQ.size(); i++) if (lruQ[i] == pg) pos = i;
    wasHit = 1'b0;
    if (pos >= 0) begin
      wasHit = 1'b1;
      lruQ.delete(pos);
      lruQ.push_back(pg);
    end else if (cacheable) begin
      if (lruQ.size() == ENTRIES) void'(lruQ.pop_front());
      lruQ.push_back(pg);
    end
  endtask

  // Issue one request, serve table reads, return result at the response cycle.
  task automatic xlate(input logic [31:0] lin, input bit withFlush,
                       output logic [31:0] phys, output logic flt, output int reads, output int idle);
    logic [31:0] expA, data;
    @(negedge clk);
    reqValid = 1'b1; reqLinAddr = lin; flushTlb = withFlush;
    @(negedge clk);
    reqValid = 1'b0; flushTlb = 1'b0;
    reads = 0; idle = 0;
    while (!respValid && idle < 200) begin
      if (memReqValid) begin
        reads++;
        if (reads == 1) expA = {dirBase, lin[31:22], 2'b00};
        else expA = {20'h10000 + {10'h0, lin[31:22]}, lin[21:12], 2'b00};
        chk("R4", "table read address", memReqAddr, expA);
        chk("R8", "ready during walk", {31'h0, reqReady}, 32'h0);
        data = memModel(memReqAddr);
        @(negedge clk);
        chk("R8", "address held", memReqAddr, expA);
        @(negedge clk);
        memRespValid = 1'b1; memRespData = data;
        @(negedge clk);
        memRespValid = 1'b0; memRespData = 32'h0;
      end else begin
        idle++;
        @(negedge clk);
      end
    end
    phys = respPhysAddr;
    flt = respFault;
    @(negedge clk);
    chk("R9", "single response", {31'h0, respValid}, 32'h0);
  endtask

  task automatic doPaged(input logic [31:0] lin, input bit withFlush, input string req);
    logic [9:0] d, t;
    logic dF, tF, ef, gotF;
    logic [31:0] phys;
    int reads, idle;
    bit wasHit;
    d = lin[31:22]; t = lin[21:12];
    dF = (d % 7 == 3); tF = (t % 5 == 4); ef = dF || tF;
    if (withFlush) lruQ.delete();
    refAccess(int'(lin[31:12]), !ef, wasHit);
    xlate(lin, withFlush, phys, gotF, reads, idle);
    if (wasHit) chk(req, "reads on hit", reads, 0);
    else chk(req, "reads on miss", reads, dF ? 1 : 2);
    chk(req, "idle cycles", idle, 0);
    chk(req, "fault flag", {31'h0, gotF}, {31'h0, ef});
    chk(req, "physical address", phys, ef ? lin : {({d, t} ^ 20'h00100), lin[11:0]});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] phys;
    logic flt;
    int reads, idle;
    int pool[$];
    logic [31:0] lfsr;
    rst_n = 1'b0; pagingEn = 1'b1; dirBase = DIRB; flushTlb = 1'b0;
    reqValid = 1'b0; reqLinAddr = 32'h0; memRespValid = 1'b0; memRespData = 32'h0;
    repeat (4) @(negedge clk);
    chk("R1", "reqReady in reset", {31'h0, reqReady}, 32'h1);
    chk("R1", "respValid in reset", {31'h0, respValid}, 32'h0);
    chk("R1", "memReqValid in reset", {31'h0, memReqValid}, 32'h0);
    rst_n = 1'b1;

    // R4 first-page mapping example, then R3 hit on the same page
    doPaged(32'h00000ABC, 1'b0, "R4");
    doPaged(32'h00000123, 1'b0, "R3");
    xlate(32'h00000FFF, 1'b0, phys, flt, reads, idle);
    chk("R3", "example hit mapping", phys, 32'h00100FFF);
    void'(lruQ.pop_back());
    lruQ.push_back(0);

    // R5 directory-level and table-level faults, never cached
    doPaged(32'h00C00010, 1'b0, "R5");
    doPaged(32'h00C00010, 1'b0, "R5");
    doPaged(32'h00004020, 1'b0, "R5");
    doPaged(32'h00004020, 1'b0, "R5");

    // R2 pass-through mode leaves the cache untouched
    pagingEn = 1'b0;
    xlate(32'h00405678, 1'b0, phys, flt, reads, idle);
    chk("R2", "pass-through address", phys, 32'h00405678);
    chk("R2", "pass-through reads", reads, 0);
    chk("R2", "pass-through latency", idle, 0);
    chk("R2", "pass-through fault", {31'h0, flt}, 32'h0);
    pagingEn = 1'b1;
    doPaged(32'h00405678, 1'b0, "R2");

    // R7 flush strobe on its own, then flush in the accept cycle
    doPaged(32'h00802345, 1'b0, "R7");
    doPaged(32'h00802345, 1'b0, "R7");
    @(negedge clk); flushTlb = 1'b1;
    @(negedge clk); flushTlb = 1'b0;
    lruQ.delete();
    doPaged(32'h00802345, 1'b0, "R7");
    doPaged(32'h00802345, 1'b0, "R7");
    doPaged(32'h00802345, 1'b1, "R7");
    doPaged(32'h00802345, 1'b0, "R7");

    // R6 directed LRU: fill all entries, refresh the oldest, then evict
    @(negedge clk); flushTlb = 1'b1;
    @(negedge clk); flushTlb = 1'b0;
    lruQ.delete();
    for (int k = 0; pool.size() < ENTRIES + 1; k++) if (k % 5 != 4) pool.push_back(k);
    for (int k = 0; k < ENTRIES; k++) doPaged(32'(pool[k]) << 12, 1'b0, "R6");
    for (int k = 0; k < ENTRIES; k++) doPaged(32'(pool[k]) << 12, 1'b0, "R6");
    doPaged(32'(pool[0]) << 12, 1'b0, "R6");
    doPaged(32'(pool[ENTRIES]) << 12, 1'b0, "R6");
    doPaged(32'(pool[1]) << 12, 1'b0, "R6");
    doPaged(32'(pool[0]) << 12, 1'b0, "R6");

    // R6 sweep over 64 pages (larger than the cache), with R7 flushes mixed in
    lfsr = 32'h1ACE5EED;
    for (int n = 0; n < 600; n++) begin
      lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
      doPaged({8'h0, lfsr[1:0], 6'h0, lfsr[5:2], lfsr[17:6]}, (n % 97 == 96), "R6");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule